// File: doc/BRIEF.md
# Splittable Rounding Multiplier

A two-stage pipelined integer multiplier whose four byte-by-byte partial-product units serve two uses. In wide mode they are summed into one 16x16 product. In split mode the two diagonal units deliver two independent 8x8 products side by side. A per-operation signed flag chooses two's-complement or unsigned operands. A per-operation round flag keeps only the upper half of each product, rounded half-up, right-aligned in its lane.

Each cycle with `in_valid_i` high starts one multiply. The mode, sign and round flags go down the pipeline with it, so a new mode may be used every cycle. Results come out exactly two clock edges after issue, marked by `out_valid_o`. Only operand bits [15:0] are used.

Top module: `split_round_mul`

## Requirements
- R1: Wide unsigned (split=0, signed=0, round=0): result_o equals the 32-bit product of op_a_i[15:0] and op_b_i[15:0] read as unsigned.
- R2: Wide signed (split=0, signed=1, round=0): result_o is the 32-bit two's-complement product. 0x8000 times 0x8000 gives 0x40000000.
- R3: Split unsigned (split=1, signed=0, round=0): result_o[15:0] = op_a_i[7:0]*op_b_i[7:0] and result_o[31:16] = op_a_i[15:8]*op_b_i[15:8]. No carry crosses between lanes.
- R4: Split signed (split=1, signed=1, round=0): each 16-bit lane is the two's-complement product of its signed bytes. 0x80 times 0x80 gives 0x4000.
- R5: Wide rounded (split=0, round=1): result_o[15:0] = (P + 0x8000) shifted right 16, arithmetically when signed. result_o[31:16] is its sign extension in signed mode and zero in unsigned mode.
- R6: Split rounded (split=1, round=1): each lane's bits [7:0] = (p + 0x80) shifted right 8, arithmetically when signed. The lane's bits [15:8] are the sign extension in signed mode and zero otherwise.
- R7: op_a_i[31:16] and op_b_i[31:16] have no effect on the result.
- R8: out_valid_o is in_valid_i delayed by exactly two rising edges. A result is accepted every cycle with no gaps.
- R9: Whenever out_valid_o is low, result_o is zero, including during and directly after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Issue a multiply this cycle |
| split_i | input | 1 | 1: two 8x8 lanes, 0: one 16x16 |
| signed_i | input | 1 | 1: two's-complement operands |
| round_i | input | 1 | 1: return rounded upper half |
| op_a_i | input | 32 | Operand A word |
| op_b_i | input | 32 | Operand B word |
| result_o | output | 32 | Product or packed lane products |
| out_valid_o | output | 1 | result_o holds a finished product |

## Verification
The bench targets the most negative operand squared in both widths. A design that sign-extends wrongly returns a negated or wrapped product there. In split mode it uses all-ones and mixed-sign bytes, where a carry leaking from the low lane would corrupt the high lane. Rounding ties and negative rounded values check the half-up direction and the extension bits, which an arithmetic-versus-logical shift mix-up would flip. Issue is back-to-back with the mode changing every cycle, so a flag that is not carried with its data, or a latency that is off by one, shows up as a mismatched result.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef struct packed {
    logic split;
    logic sgn;
    logic rnd;
  } srm_mode_t;
endpackage

// File: rtl/srm_pp_unit.sv
// One (W+1)x(W+1) signed multiplier; the extra bit is zero or the operand's sign.
module srm_pp_unit #(
  parameter int unsigned W    = 8,
  localparam int unsigned PP_W = 2*W + 2
) (
  input  logic [W-1:0]           a_i,
  input  logic [W-1:0]           b_i,
  input  logic                   a_sx_i,
  input  logic                   b_sx_i,
  output logic signed [PP_W-1:0] p_o
);
  logic signed [W:0] a_x, b_x;

  assign a_x = {a_sx_i & a_i[W-1], a_i};
  assign b_x = {b_sx_i & b_i[W-1], b_i};
  assign p_o = PP_W'(a_x) * PP_W'(b_x);
endmodule

// File: rtl/srm_combine.sv
module srm_combine
  import srm_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned PP_W  = 2*LANE_W + 2,
  localparam int unsigned SUM_W = 4*LANE_W + 1,
  localparam int unsigned RES_W = 4*LANE_W
) (
  input  logic signed [PP_W-1:0] pp_i [4],
  input  srm_mode_t              mode_i,
  output logic [RES_W-1:0]       res_o
);
  localparam logic signed [SUM_W-1:0] HALF_FULL = SUM_W'(1) << (2*LANE_W-1);
  localparam logic signed [PP_W-1:0]  HALF_LANE = PP_W'(1) << (LANE_W-1);

  logic signed [SUM_W-1:0] ext [4];
  logic signed [SUM_W-1:0] full, full_r;
  logic [2*LANE_W-1:0]     lane_res [2];
  logic [RES_W-1:0]        wide_res;

  always_comb begin
    for (int k = 0; k < 4; k++) ext[k] = pp_i[k];
    full   = ext[0] + (ext[1] <<< LANE_W) + (ext[2] <<< LANE_W) + (ext[3] <<< 2*LANE_W);
    full_r = full + HALF_FULL;
    wide_res = mode_i.rnd ? {{(2*LANE_W){full_r[SUM_W-1]}}, full_r[RES_W-1:2*LANE_W]}
                          : full[RES_W-1:0];
  end

  // lane 0 uses a_lo*b_lo (pp 0), lane 1 uses a_hi*b_hi (pp 3)
  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic signed [PP_W-1:0] lp, lr;
    always_comb begin
      lp = pp_i[3*k];
      lr = lp + HALF_LANE;
      lane_res[k] = mode_i.rnd ? {{LANE_W{lr[PP_W-1]}}, lr[2*LANE_W-1:LANE_W]}
                               : lp[2*LANE_W-1:0];
    end
  end

  assign res_o = mode_i.split ? {lane_res[1], lane_res[0]} : wide_res;
endmodule

// File: rtl/split_round_mul.sv
module split_round_mul
  import srm_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned WORD_W = 4*LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              split_i,
  input  logic              signed_i,
  input  logic              round_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic [WORD_W-1:0] result_o,
  output logic              out_valid_o
);
  localparam int unsigned PP_W  = 2*LANE_W + 2;
  localparam int unsigned HALFS = 2;

  logic signed [PP_W-1:0] pp_d [4];
  logic signed [PP_W-1:0] pp_q [4];
  srm_mode_t              mode_d, mode_q1, mode_q2;
  logic                   vld_q1;
  logic [WORD_W-1:0]      comb_res;
  logic [HALFS-1:0]       sx;

  assign mode_d = '{split: split_i, sgn: signed_i, rnd: round_i};

  // high half always carries the sign; low half only when it is a lane of its own
  for (genvar h = 0; h < HALFS; h++) begin : g_sx
    assign sx[h] = signed_i & ((h == HALFS-1) | split_i);
  end

  for (genvar i = 0; i < HALFS; i++) begin : g_a
    for (genvar j = 0; j < HALFS; j++) begin : g_b
      srm_pp_unit #(.W(LANE_W)) u_pp (
        .a_i   (op_a_i[i*LANE_W +: LANE_W]),
        .b_i   (op_b_i[j*LANE_W +: LANE_W]),
        .a_sx_i(sx[i]),
        .b_sx_i(sx[j]),
        .p_o   (pp_d[2*i+j])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 4; k++) pp_q[k] <= '0;
      mode_q1 <= '0;
      vld_q1  <= 1'b0;
    end else begin
      for (int k = 0; k < 4; k++) pp_q[k] <= pp_d[k];
      mode_q1 <= mode_d;
      vld_q1  <= in_valid_i;
    end
  end

  srm_combine #(.LANE_W(LANE_W)) u_comb (
    .pp_i  (pp_q),
    .mode_i(mode_q1),
    .res_o (comb_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      out_valid_o <= 1'b0;
      mode_q2     <= '0;
    end else begin
      result_o    <= vld_q1 ? comb_res : '0;
      out_valid_o <= vld_q1;
      mode_q2     <= mode_q1;
    end
  end

  assert_lat_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ##1 out_valid_o);
  assert_lat_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ##1 !out_valid_o);
  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> result_o == '0);
  assert_wide_rnd_ext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && mode_q2.rnd && !mode_q2.split) |->
      result_o[WORD_W-1:2*LANE_W] == {(2*LANE_W){result_o[2*LANE_W-1] & mode_q2.sgn}});
  for (genvar k = 0; k < 2; k++) begin : g_lane_chk
    assert_lane_rnd_ext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && mode_q2.rnd && mode_q2.split) |->
        result_o[k*2*LANE_W+LANE_W +: LANE_W] ==
          {LANE_W{result_o[k*2*LANE_W+LANE_W-1] & mode_q2.sgn}});
  end
  for (genvar k = 0; k < 4; k++) begin : g_pp_chk
    assert_pp_nonneg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_q1 && !mode_q1.sgn) |-> !pp_q[k][PP_W-1]);
  end
endmodule

// File: tb/sim_split_round_mul.sv
`timescale 1ns/1ps
module sim_split_round_mul;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, split_i = 1'b0, signed_i = 1'b0, round_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic [31:0] result_o;
  logic        out_valid_o;

  int nchk = 0;
  int nfail = 0;

  always #2 clk_i = ~clk_i;

  split_round_mul u0 (.*);

  // {split, signed, round, a, b}
  localparam int NV = 22;
  localparam logic [66:0] VEC [NV] = '{
    {3'b000, 32'h0000FFFF, 32'h0000FFFF},
    {3'b000, 32'h00001234, 32'h00005678},
    {3'b000, 32'h00000000, 32'h0000ABCD},
    {3'b010, 32'h00008000, 32'h00008000},
    {3'b010, 32'h0000FFFF, 32'h00000001},
    {3'b010, 32'h00007FFF, 32'h00008000},
    {3'b010, 32'hFFFF8001, 32'h00007FFF},
    {3'b100, 32'h0000FFFF, 32'h0000FFFF},
    {3'b100, 32'h000080FF, 32'h000002FF},
    {3'b100, 32'hDEAD1020, 32'hBEEF3040},
    {3'b110, 32'h00008080, 32'h00008080},
    {3'b110, 32'h00007F80, 32'h0000FF7F},
    {3'b110, 32'h000001FF, 32'h0000FF01},
    {3'b001, 32'h0000FFFF, 32'h0000FFFF},
    {3'b011, 32'h00008000, 32'h00008000},
    {3'b011, 32'h0000FFFF, 32'h00008000},
    {3'b011, 32'h00000001, 32'h00008000},
    {3'b011, 32'h0000C000, 32'h00000003},
    {3'b001, 32'h00000100, 32'h00000080},
    {3'b101, 32'h0000FFFF, 32'h0000FFFF},
    {3'b111, 32'h00008080, 32'h0000807F},
    {3'b111, 32'h0000FF10, 32'h00000808}
  };

  function automatic logic [31:0] ref_mul(logic sp, logic sg, logic rd,
                                          logic [31:0] a, logic [31:0] b);
    longint x, y, p, r;
    logic [31:0] res;
    if (!sp) begin
      x = sg ? longint'($signed(a[15:0])) : longint'(a[15:0]);
      y = sg ? longint'($signed(b[15:0])) : longint'(b[15:0]);
      p = x * y;
      r = (p + 32768) >>> 16;
      res = rd ? r[31:0] : p[31:0];
    end else begin
      for (int k = 0; k < 2; k++) begin
        x = sg ? longint'($signed(a[8*k +: 8])) : longint'(a[8*k +: 8]);
        y = sg ? longint'($signed(b[8*k +: 8])) : longint'(b[8*k +: 8]);
        p = x * y;
        r = (p + 128) >>> 8;
        res[16*k +: 16] = rd ? r[15:0] : p[15:0];
      end
    end
    return res;
  endfunction

  function automatic string tag_of(logic sp, logic sg, logic rd);
    if (rd) return sp ? "R6" : "R5";
    if (sp) return sg ? "R4" : "R3";
    return sg ? "R2" : "R1";
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(logic v, logic sp, logic sg, logic rd, logic [31:0] a, logic [31:0] b);
    in_valid_i = v; split_i = sp; signed_i = sg; round_i = rd; op_a_i = a; op_b_i = b;
  endtask

  logic [31:0] exp_a [NV];
  string       tag_a [NV];

  initial begin
    int head = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R9 reset valid", {31'b0, out_valid_o}, 32'h0);
    chk("R9 reset result", result_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // isolated issue: valid appears on the second edge, not the first
    drive(1'b1, 1'b0, 1'b0, 1'b0, 32'h00000003, 32'h00000005);
    @(negedge clk_i);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    chk("R8 not after one edge", {31'b0, out_valid_o}, 32'h0);
    @(negedge clk_i);
    chk("R8 valid after two edges", {31'b0, out_valid_o}, 32'h1);
    chk("R1 isolated result", result_o, 32'd15);
    @(negedge clk_i);
    chk("R9 idle after result", result_o, 32'h0);

    // upper operand halves are junk
    drive(1'b1, 1'b0, 1'b0, 1'b0, 32'hABCD0003, 32'h12340005);
    @(negedge clk_i);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF0203, 32'h55550405);
    @(negedge clk_i);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    chk("R7 wide junk upper", result_o, 32'd15);
    @(negedge clk_i);
    chk("R7 split junk upper", result_o, 32'h0008_000F);
    @(negedge clk_i);

    // back-to-back stream, mode changes each cycle
    for (int i = 0; i < NV + 3; i++) begin
      if (out_valid_o) begin
        if (head < NV) begin
          chk(tag_a[head], result_o, exp_a[head]);
          head++;
        end else chk("R8 extra output", 32'h1, 32'h0);
      end
      if (i < NV) begin
        logic [66:0] v = VEC[i];
        exp_a[i] = ref_mul(v[66], v[65], v[64], v[63:32], v[31:0]);
        tag_a[i] = tag_of(v[66], v[65], v[64]);
        drive(1'b1, v[66], v[65], v[64], v[63:32], v[31:0]);
      end else drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
      @(negedge clk_i);
    end
    chk("R8 stream output count", head, NV);
    chk("R9 idle after stream", result_o, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule